// File: doc/BRIEF.md
# Second-Level Page-Table Walker

This block turns a DMA input address into a physical page by walking a radix-512 second-level translation table held in memory. The table can have one to five levels. A request carries the input address, the requested read/write rights, the pointer to the root table and the number of paging levels. Once accepted, the walker issues one 64-bit memory read per level over a request/response port. It never has more than one read in flight. It checks every fetched entry before it descends.

A walk ends in one of two ways. It may end on a translated page, given as the page base, the page-size shift and the entry's permission bits. Otherwise it ends on a single fault code chosen by a fixed priority. Fetch errors come first. The permission check runs before the reserved-bit check. Large pages at the two middle levels are accepted only when the matching capability input allows them. The result appears as a one-cycle `done` pulse.

The entry layout used throughout is:

- bit 0: read right
- bit 1: write right
- bit 7: page-size flag
- bits 63:52: reserved at every level
- bits 51:12: the next table base or the page base

Top module: `slpt_walker`

## Requirements
- R1: A walk starts at level `reqLevels`−1 and descends one level per memory read down to level 0. No level is skipped, so a walk that ends at level k issues exactly `reqLevels`−k reads.
- R2: The entry address at level L is the current table base with bits 11:0 cleared, ORed with 8 × `reqAddr[12+9L +: 9]`. At the top level the current table is `reqRoot`. Below it, the current table is the entry fetched one level up.
- R3: A read that returns `memRspErr` ends the walk with a fault. The fault code is 1 if bits 63:12 of the entry address equal bits 63:12 of `reqRoot`, and 2 otherwise.
- R4: Both the requested rights (`reqPerm`, bit 0 read, bit 1 write) and the entry rights (bits 1:0) are ANDed with `permMask`. The check passes when every masked requested bit is also set in the masked entry rights. A requested right that `permMask` clears has no effect.
- R5: A failed permission check gives one of three fault codes. Code 3 (not present) applies when both masked entry rights are clear. Otherwise, code 4 (read denied) applies when `reqPerm[0]` differs from the masked entry read bit. Otherwise the code is 5 (write denied).
- R6: An entry that passes the permission check faults with code 6 if any bit in 63:52 is set, or if bit 7 is set at level 0, 3 or 4. A permission fault takes priority over a reserved-bit fault in the same entry.
- R7: Bit 7 set at level 1 or 2 marks a large page. It is accepted when `capLargePage[L-1]` is 1. The walk then ends with shift 12+9L (21 or 30) and the entry with bits below that shift cleared as the base. When the capability bit is 0, the walk faults with code 7.
- R8: An entry at level 0 that passes the checks ends the walk. The base is the entry with bits 11:0 cleared, the shift is 12, and `pagePerm` is the masked entry rights.
- R9: A request whose `reqLevels` is 0 or above 5 issues no memory read. It raises `done` with fault code 8 in the cycle after acceptance.
- R10: `memReqValid` stays high with a stable `memReqAddr` until `memReqReady` is seen. After a handshake, no new read is issued until the response arrives.
- R11: `done` is a one-cycle pulse, and `reqReady` is low while a walk is active or `done` is high. `fault` is high exactly when `faultCode` is nonzero, and a successful walk reports code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqAddr | input | 64 | Input address to translate |
| reqPerm | input | 2 | Requested rights, bit 0 read, bit 1 write |
| reqRoot | input | 64 | Root table pointer |
| reqLevels | input | 3 | Number of paging levels |
| permMask | input | 2 | Valid-permission mask applied to both rights |
| capLargePage | input | 2 | Bit 0 enables 2 MiB pages at level 1, bit 1 enables 1 GiB pages at level 2 |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory read request accepted |
| memReqAddr | output | 64 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read from memory |
| memRspErr | input | 1 | Read failed |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 4 | Fault reason, 0 on success |
| pageBase | output | 64 | Translated page base |
| pageShift | output | 6 | log2 of the page size |
| pagePerm | output | 2 | Masked entry rights of the final entry |

## Verification
The hardest cases to reach are entries that break several rules at once, and fetch failures that must be told apart by which table page they fall in. A single table image is therefore built in which some leaves carry both a permission violation and reserved bits, and some carry a page-size flag at level 0. Read errors are planted both in the root page and in an intermediate table. Stalls on the request side are inserted on a repeat walk to show that the address holds. The same leaves are revisited through 3- and 5-level roots and under different permission masks and capability settings, so one memory image covers every fault priority.

// File: rtl/slpt_pkg.sv
package slpt_pkg;

  localparam int ENTRY_W     = 64;
  localparam int PAGE_SHIFT  = 12;
  localparam int IDX_W       = 9;
  localparam int LVL_W       = 3;
  localparam int PERM_W      = 2;
  localparam int PS_BIT      = 7;
  localparam int RSVD_HI_LSB = 52;
  localparam int SHIFT_W     = 6;

  typedef enum logic [3:0] {
    FC_NONE        = 4'd0,
    FC_ROOT_READ   = 4'd1,
    FC_ENTRY_READ  = 4'd2,
    FC_NOT_PRESENT = 4'd3,
    FC_READ_DENY   = 4'd4,
    FC_WRITE_DENY  = 4'd5,
    FC_RESERVED    = 4'd6,
    FC_BAD_LARGE   = 4'd7,
    FC_BAD_LEVELS  = 4'd8
  } faultCodeT;

  typedef struct packed {
    logic load;
    logic descend;
    logic finishWalk;
    logic finishBadLevels;
  } walkStrobeT;

  // Bits that must be zero in an entry fetched at a given level.
  function automatic logic [ENTRY_W-1:0] rsvdMask(input logic [LVL_W-1:0] lvl);
    logic [ENTRY_W-1:0] m;
    m = '0;
    m[ENTRY_W-1:RSVD_HI_LSB] = '1;
    if (lvl == 3'd0 || lvl >= 3'd3) m[PS_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/slpt_ctrl.sv
module slpt_ctrl
  import slpt_pkg::*;
#(
  parameter int MAX_LEVELS = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LVL_W-1:0] reqLevels,
  input  logic             resultPending,
  output logic             reqReady,
  output logic             memReqValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             walkEnds,
  output walkStrobeT       strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} stateT;

  stateT state, stateNext;
  logic  badLevels;

  assign badLevels   = (reqLevels == '0) || (int'(reqLevels) > MAX_LEVELS);
  assign reqReady    = (state == ST_IDLE) && !resultPending;
  assign memReqValid = (state == ST_ISSUE);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && reqReady) begin
          if (badLevels) begin
            strobe.finishBadLevels = 1'b1;
          end else begin
            strobe.load = 1'b1;
            stateNext   = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (memReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (walkEnds) begin
            strobe.finishWalk = 1'b1;
            stateNext         = ST_IDLE;
          end else begin
            strobe.descend = 1'b1;
            stateNext      = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R10: a read handed to memory is not followed by another one until its response
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R11: a request is never taken while a walk is in progress
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || (state == ST_WAIT)) |-> !reqReady);

endmodule

// File: rtl/slpt_datapath.sv
module slpt_datapath
  import slpt_pkg::*;
#(
  parameter int LARGE_LVLS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkStrobeT            strobe,
  input  logic [ENTRY_W-1:0]    reqAddr,
  input  logic [PERM_W-1:0]     reqPerm,
  input  logic [ENTRY_W-1:0]    reqRoot,
  input  logic [LVL_W-1:0]      reqLevels,
  input  logic [PERM_W-1:0]     permMask,
  input  logic [LARGE_LVLS-1:0] capLargePage,
  input  logic [ENTRY_W-1:0]    memRspData,
  input  logic                  memRspErr,
  output logic [ENTRY_W-1:0]    memReqAddr,
  output logic                  walkEnds,
  output logic                  done,
  output logic                  fault,
  output logic [3:0]            faultCode,
  output logic [ENTRY_W-1:0]    pageBase,
  output logic [SHIFT_W-1:0]    pageShift,
  output logic [PERM_W-1:0]     pagePerm
);

  localparam int ENTRY_BYTES_LOG = 3;

  logic [ENTRY_W-1:0] vaReg, rootReg, tblBase;
  logic [PERM_W-1:0]  permReg;
  logic [LVL_W-1:0]   lvl;

  logic [SHIFT_W-1:0] lvlShift;
  logic [IDX_W-1:0]   entryIdx;
  logic [ENTRY_W-1:0] entryAddr;
  logic [PERM_W-1:0]  entPerm, wantPerm;
  logic               capOk;

  faultCodeT          vCode;
  logic [ENTRY_W-1:0] vBase;
  logic [SHIFT_W-1:0] vShift;

  assign lvlShift  = SHIFT_W'(PAGE_SHIFT) + SHIFT_W'(IDX_W) * SHIFT_W'(lvl);
  assign entryIdx  = IDX_W'(vaReg >> lvlShift);
  assign entryAddr = {tblBase[ENTRY_W-1:PAGE_SHIFT], PAGE_SHIFT'(0)}
                   | (ENTRY_W'(entryIdx) << ENTRY_BYTES_LOG);
  assign memReqAddr = entryAddr;

  assign entPerm  = memRspData[PERM_W-1:0] & permMask;
  assign wantPerm = permReg & permMask;

  // Capability lookup for the levels that may hold a large page.
  always_comb begin
    capOk = 1'b0;
    for (int k = 1; k <= LARGE_LVLS; k++) begin
      if (int'(lvl) == k) capOk = capLargePage[k-1];
    end
  end

  // Verdict on the entry that arrives in this cycle, in fixed priority order.
  always_comb begin
    vCode    = FC_NONE;
    vBase    = '0;
    vShift   = '0;
    walkEnds = 1'b0;
    if (memRspErr) begin
      walkEnds = 1'b1;
      vCode    = (entryAddr[ENTRY_W-1:PAGE_SHIFT] == rootReg[ENTRY_W-1:PAGE_SHIFT])
               ? FC_ROOT_READ : FC_ENTRY_READ;
    end else if ((entPerm & wantPerm) != wantPerm) begin
      walkEnds = 1'b1;
      if (entPerm == '0)                vCode = FC_NOT_PRESENT;
      else if (permReg[0] != entPerm[0]) vCode = FC_READ_DENY;
      else                               vCode = FC_WRITE_DENY;
    end else if ((memRspData & rsvdMask(lvl)) != '0) begin
      walkEnds = 1'b1;
      vCode    = FC_RESERVED;
    end else if (memRspData[PS_BIT] && (lvl != '0)) begin
      walkEnds = 1'b1;
      if (capOk) begin
        vShift = lvlShift;
        vBase  = memRspData & ~((ENTRY_W'(1) << lvlShift) - ENTRY_W'(1));
      end else begin
        vCode = FC_BAD_LARGE;
      end
    end else if (lvl == '0) begin
      walkEnds = 1'b1;
      vShift   = SHIFT_W'(PAGE_SHIFT);
      vBase    = {memRspData[ENTRY_W-1:PAGE_SHIFT], PAGE_SHIFT'(0)};
    end
  end

  // Walk state.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg   <= '0;
      rootReg <= '0;
      tblBase <= '0;
      permReg <= '0;
      lvl     <= '0;
    end else if (strobe.load) begin
      vaReg   <= reqAddr;
      rootReg <= reqRoot;
      tblBase <= reqRoot;
      permReg <= reqPerm;
      lvl     <= reqLevels - LVL_W'(1);
    end else if (strobe.descend) begin
      tblBase <= memRspData;
      lvl     <= lvl - LVL_W'(1);
    end
  end

  // Result registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      fault     <= 1'b0;
      faultCode <= FC_NONE;
      pageBase  <= '0;
      pageShift <= '0;
      pagePerm  <= '0;
    end else begin
      done <= strobe.finishWalk || strobe.finishBadLevels;
      if (strobe.finishBadLevels) begin
        fault     <= 1'b1;
        faultCode <= FC_BAD_LEVELS;
        pageBase  <= '0;
        pageShift <= '0;
        pagePerm  <= '0;
      end else if (strobe.finishWalk) begin
        fault     <= (vCode != FC_NONE);
        faultCode <= vCode;
        pageBase  <= vBase;
        pageShift <= vShift;
        pagePerm  <= (vCode == FC_NONE) ? entPerm : '0;
      end
    end
  end

  // R7: a successful result is a 4 KiB, 2 MiB or 1 GiB page
  assert_shift_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (pageShift == 6'd12 || pageShift == 6'd21 || pageShift == 6'd30));

  // R11: the fault flag agrees with the code
  assert_fault_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fault == (faultCode != 4'd0)));

  // R8: a successful page base has no bits below its shift
  assert_base_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (pageBase[11:0] == 12'd0));

endmodule

// File: rtl/slpt_walker.sv
module slpt_walker
  import slpt_pkg::*;
#(
  parameter int MAX_LEVELS = 5,
  parameter int LARGE_LVLS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [63:0]           reqAddr,
  input  logic [1:0]            reqPerm,
  input  logic [63:0]           reqRoot,
  input  logic [2:0]            reqLevels,
  input  logic [1:0]            permMask,
  input  logic [LARGE_LVLS-1:0] capLargePage,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [63:0]           memReqAddr,
  input  logic                  memRspValid,
  input  logic [63:0]           memRspData,
  input  logic                  memRspErr,
  output logic                  done,
  output logic                  fault,
  output logic [3:0]            faultCode,
  output logic [63:0]           pageBase,
  output logic [5:0]            pageShift,
  output logic [1:0]            pagePerm
);

  walkStrobeT strobe;
  logic       walkEnds;

  slpt_ctrl #(.MAX_LEVELS(MAX_LEVELS)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqLevels     (reqLevels),
    .resultPending (done),
    .reqReady      (reqReady),
    .memReqValid   (memReqValid),
    .memReqReady   (memReqReady),
    .memRspValid   (memRspValid),
    .walkEnds      (walkEnds),
    .strobe        (strobe)
  );

  slpt_datapath #(.LARGE_LVLS(LARGE_LVLS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqPerm      (reqPerm),
    .reqRoot      (reqRoot),
    .reqLevels    (reqLevels),
    .permMask     (permMask),
    .capLargePage (capLargePage),
    .memRspData   (memRspData),
    .memRspErr    (memRspErr),
    .memReqAddr   (memReqAddr),
    .walkEnds     (walkEnds),
    .done         (done),
    .fault        (fault),
    .faultCode    (faultCode),
    .pageBase     (pageBase),
    .pageShift    (pageShift),
    .pagePerm     (pagePerm)
  );

  // R10: a pending read holds its address until memory takes it
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R9: an unusable level count completes at once with code 8
  assert_bad_levels_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqLevels == 3'd0 || reqLevels > 3'd5))
      |=> (done && fault && faultCode == 4'd8 && !memReqValid));

  // R11: the result strobe lasts one cycle and blocks new requests
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!reqReady ##1 !done));

endmodule

// File: tb/slpt_walker_bench.sv
module slpt_walker_bench;

  typedef struct {
    bit          isFault;
    logic [3:0]  code;
    logic [63:0] base;
    int          shift;
    logic [1:0]  perm;
    int          reads;
    string       tag;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqAddr = '0;
  logic [1:0]  reqPerm = '0;
  logic [63:0] reqRoot = '0;
  logic [2:0]  reqLevels = '0;
  logic [1:0]  permMask = 2'b11;
  logic [1:0]  capLargePage = 2'b00;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        done, fault;
  logic [3:0]  faultCode;
  logic [63:0] pageBase;
  logic [5:0]  pageShift;
  logic [1:0]  pagePerm;

  int checks = 0;
  int errors = 0;
  int readCount = 0;
  int stallLeft = 0;
  bit pending = 0;
  logic [63:0] pendAddr;

  logic [63:0] mem [logic [63:0]];
  bit          errAddr [logic [63:0]];
  expT         sbQ[$];

  always #2 clk = ~clk;

  slpt_walker u_slpt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqPerm(reqPerm), .reqRoot(reqRoot), .reqLevels(reqLevels),
    .permMask(permMask), .capLargePage(capLargePage),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .done(done), .fault(fault), .faultCode(faultCode), .pageBase(pageBase),
    .pageShift(pageShift), .pagePerm(pagePerm)
  );

  localparam logic [63:0] ROOT  = 64'h0000_0000_1000_0000;
  localparam logic [63:0] TBL_A = 64'h0000_0000_2000_0000;
  localparam logic [63:0] TBL_B = 64'h0000_0000_3000_0000;
  localparam logic [63:0] TBL_C = 64'h0000_0000_4000_0000;
  localparam logic [63:0] ROOT5 = 64'h0000_0000_6000_0000;

  function automatic logic [63:0] slot(logic [63:0] tbl, int idx);
    return {tbl[63:12], 12'h000} + 64'(idx) * 64'd8;
  endfunction

  function automatic logic [63:0] mkVa(int i4, int i3, int i2, int i1, int i0, int off);
    return (64'(i4) << 48) | (64'(i3) << 39) | (64'(i2) << 30) | (64'(i1) << 21)
         | (64'(i0) << 12) | 64'(off);
  endfunction

  // Expected result from the requirements.
  function automatic expT refWalk(logic [63:0] va, logic [1:0] rp, logic [63:0] root,
                                  int lv, logic [1:0] pm, logic [1:0] cap);
    expT r;
    logic [63:0] tbl, ea, e, rsv;
    logic [1:0] ep, qp;
    r.isFault = 0; r.code = 0; r.base = 0; r.shift = 0; r.perm = 0; r.reads = 0; r.tag = "";
    if (lv < 1 || lv > 5) begin
      r.isFault = 1; r.code = 4'd8; return r;                       // R9
    end
    tbl = root;
    for (int l = lv - 1; l >= 0; l--) begin
      ea = {tbl[63:12], 12'h000} | (((va >> (12 + 9 * l)) & 64'h1FF) << 3);  // R2
      r.reads++;
      if (errAddr.exists(ea)) begin                                  // R3
        r.isFault = 1; r.code = (ea[63:12] == root[63:12]) ? 4'd1 : 4'd2; return r;
      end
      e  = mem.exists(ea) ? mem[ea] : 64'd0;
      ep = e[1:0] & pm;
      qp = rp & pm;
      if ((ep & qp) != qp) begin                                     // R4, R5
        r.isFault = 1;
        if (ep == 2'b00)      r.code = 4'd3;
        else if (rp[0] != ep[0]) r.code = 4'd4;
        else                  r.code = 4'd5;
        return r;
      end
      rsv = 64'hFFF0_0000_0000_0000;                                 // R6
      if (l == 0 || l >= 3) rsv[7] = 1'b1;
      if ((e & rsv) != 0) begin r.isFault = 1; r.code = 4'd6; return r; end
      if (e[7] && l > 0) begin                                       // R7
        if (cap[l-1]) begin
          r.shift = 12 + 9 * l;
          r.base  = (e >> r.shift) << r.shift;
          r.perm  = ep;
        end else begin
          r.isFault = 1; r.code = 4'd7;
        end
        return r;
      end
      if (l == 0) begin                                              // R8
        r.shift = 12; r.base = {e[63:12], 12'h000}; r.perm = ep; return r;
      end
      tbl = e;                                                       // R1
    end
    return r;
  endfunction

  // Memory model: captures at most one read, answers on the next falling edge.
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      memReqReady = 1'b0;
      if (pending) begin
        memRspValid = 1'b1;
        memRspErr   = errAddr.exists(pendAddr);
        memRspData  = mem.exists(pendAddr) ? mem[pendAddr] : 64'd0;
        pending     = 0;
      end else if (memReqValid) begin
        if (stallLeft > 0) begin
          stallLeft--;
        end else begin
          memReqReady = 1'b1;
          pendAddr    = memReqAddr;
          pending     = 1;
          readCount++;
        end
      end
    end
  end

  // Monitor: compares every result against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        expT x;
        checks++;
        if (sbQ.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected done: actual code %0d expected no result", faultCode);
        end else begin
          x = sbQ.pop_front();
          if (fault !== x.isFault || faultCode !== x.code || readCount != x.reads ||
              (!x.isFault && (pageBase !== x.base || int'(pageShift) != x.shift ||
                              pagePerm !== x.perm))) begin
            errors++;
            $display("FAIL %s: actual fault=%0b code=%0d base=%h shift=%0d perm=%0b reads=%0d expected fault=%0b code=%0d base=%h shift=%0d perm=%0b reads=%0d",
                     x.tag, fault, faultCode, pageBase, pageShift, pagePerm, readCount,
                     x.isFault, x.code, x.base, x.shift, x.perm, x.reads);
          end
        end
      end
    end
  end

  task automatic runWalk(string tag, logic [63:0] va, logic [1:0] rp, logic [63:0] root,
                         int lv, logic [1:0] pm, logic [1:0] cap, int stall);
    expT x;
    x = refWalk(va, rp, root, lv, pm, cap);
    x.tag = tag;
    sbQ.push_back(x);
    do @(negedge clk); while (!reqReady);
    readCount    = 0;
    stallLeft    = stall;
    permMask     = pm;
    capLargePage = cap;
    reqAddr      = va;
    reqPerm      = rp;
    reqRoot      = root;
    reqLevels    = 3'(lv);
    reqValid     = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (sbQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Table image.
    mem[slot(ROOT, 1)]   = TBL_A | 64'h3;
    mem[slot(ROOT, 13)]  = TBL_A | 64'h83;                 // size flag at level 3
    mem[slot(TBL_A, 2)]  = TBL_B | 64'h3;
    mem[slot(TBL_A, 11)] = 64'h0000_0000_C000_0083;        // 1 GiB page
    mem[slot(TBL_B, 3)]  = TBL_C | 64'h3;
    mem[slot(TBL_B, 10)] = 64'h0000_0000_8020_0083;        // 2 MiB page
    mem[slot(TBL_C, 4)]  = 64'h0000_0012_3456_7001;        // read-only leaf
    mem[slot(TBL_C, 5)]  = 64'h0000_0000_0ABC_8002;        // write-only leaf
    mem[slot(TBL_C, 6)]  = 64'h0000_0000_0DEF_0000;        // no rights
    mem[slot(TBL_C, 7)]  = 64'h1000_0000_0001_1001;        // read-only + reserved
    mem[slot(TBL_C, 8)]  = 64'h1000_0000_0002_2003;        // reserved
    mem[slot(TBL_C, 9)]  = 64'h0000_0000_0003_3083;        // size flag at level 0
    mem[slot(ROOT5, 1)]  = ROOT | 64'h3;
    errAddr[slot(ROOT, 7)]   = 1;
    errAddr[slot(TBL_A, 12)] = 1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (reqReady !== 1'b1 || done !== 1'b0 || memReqValid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: actual ready=%0b done=%0b memReqValid=%0b expected 1 0 0",
               reqReady, done, memReqValid);
    end

    runWalk("R1 R2 R8 4-level read",        mkVa(0,1,2,3,4,'h321), 2'b01, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R5 write on read-only",        mkVa(0,1,2,3,4,0),     2'b10, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R5 read on write-only",        mkVa(0,1,2,3,5,0),     2'b01, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R5 not present",               mkVa(0,1,2,3,6,0),     2'b01, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R6 permission before reserved", mkVa(0,1,2,3,7,0),    2'b11, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R6 reserved high bits",        mkVa(0,1,2,3,8,0),     2'b11, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R6 size flag at level 0",      mkVa(0,1,2,3,9,0),     2'b01, ROOT, 4, 2'b11, 2'b11, 0);
    runWalk("R6 size flag at level 3",      mkVa(0,13,2,3,4,0),    2'b01, ROOT, 4, 2'b11, 2'b11, 0);
    runWalk("R7 2MiB page enabled",         mkVa(0,1,2,10,0,'h77), 2'b11, ROOT, 4, 2'b11, 2'b01, 0);
    runWalk("R7 2MiB page disabled",        mkVa(0,1,2,10,0,0),    2'b11, ROOT, 4, 2'b11, 2'b10, 0);
    runWalk("R7 1GiB page enabled",         mkVa(0,1,11,0,0,0),    2'b10, ROOT, 4, 2'b11, 2'b10, 0);
    runWalk("R7 1GiB page disabled",        mkVa(0,1,11,0,0,0),    2'b10, ROOT, 4, 2'b11, 2'b01, 0);
    runWalk("R3 root page read error",      mkVa(0,7,0,0,0,0),     2'b01, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R3 table entry read error",    mkVa(0,1,12,0,0,0),    2'b01, ROOT, 4, 2'b11, 2'b00, 0);
    runWalk("R9 zero levels",               mkVa(0,1,2,3,4,0),     2'b01, ROOT, 0, 2'b11, 2'b00, 0);
    runWalk("R9 six levels",                mkVa(0,1,2,3,4,0),     2'b01, ROOT, 6, 2'b11, 2'b00, 0);
    runWalk("R1 3-level walk",              mkVa(0,0,2,3,4,'h10),  2'b01, TBL_A, 3, 2'b11, 2'b00, 0);
    runWalk("R1 5-level walk",              mkVa(1,1,2,3,4,'h20),  2'b01, ROOT5, 5, 2'b11, 2'b00, 0);
    runWalk("R4 masked write right ignored", mkVa(0,1,2,3,4,0),    2'b10, ROOT, 4, 2'b01, 2'b00, 0);
    runWalk("R10 stalled request",          mkVa(0,1,2,3,4,'h8),   2'b01, ROOT, 4, 2'b11, 2'b00, 3);

    // R11: busy walker refuses a second request.
    do @(negedge clk); while (!reqReady);
    begin
      expT x;
      x = refWalk(mkVa(0,1,2,3,4,0), 2'b01, ROOT, 4, 2'b11, 2'b00);
      x.tag = "R11 second walk";
      sbQ.push_back(x);
    end
    readCount = 0; reqAddr = mkVa(0,1,2,3,4,0); reqPerm = 2'b01; reqRoot = ROOT;
    reqLevels = 3'd4; permMask = 2'b11; capLargePage = 2'b00; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (reqReady !== 1'b0) begin
      errors++;
      $display("FAIL R11 busy: actual reqReady=%0b expected 0", reqReady);
    end
    while (sbQ.size() != 0) @(negedge clk);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule